// File: doc/BRIEF.md
# Prioritized GPIO Port Pin Multiplexer

This block controls a four-pin general-purpose I/O port. Each pin can be driven by the port's own data register, or it can be taken over by one of three peripheral functions: a serial line (transmit or receive), a timer output-compare channel, or a PWM channel. Each pin has a fixed priority chain that picks the owner. Serial beats timer, timer beats PWM, and PWM beats general-purpose I/O. The owner sets both the pin's output value and its output enable toward the pad.

Software uses a small synchronous register bus with address, write enable, write data and combinational read data. The bus reaches three registers:

- a data register;
- a direction register;
- a read-only input register that shows the synchronized pin states.

Pad inputs pass through a two-flop synchronizer. The synchronized value feeds the input register, the data register read path and a per-pin capture tap for an external timer. Peripheral enables and output values arrive as plain input signals.

Top module: `gpio_mux_port`

## Requirements
- R1: With a pin's serial enable high and its serial-transmit select high, the pin's output enable is 1 and its output equals the serial output value, whatever the timer, PWM and register settings are.
- R2: With a pin's serial enable high and its serial-transmit select low (receive), the pin's output enable is 0, whatever the timer, PWM and direction settings are.
- R3: With serial disabled and the timer channel enable high, the output enable is 1 and the output equals the timer output value, whatever the PWM settings are.
- R4: With serial and timer disabled and the PWM enable high, the output enable is 1 and the output equals the PWM output value.
- R5: With no peripheral enabled, the output equals the data register bit and the output enable equals the direction bit.
- R6: A read at address 0 returns, in bits 3..0, the data register bit where the direction bit is 1 and the synchronized pin where it is 0. Bits 7..4 read 0. A write at address 0 loads data bits 3..0.
- R7: A read at address 2 returns the synchronized pins in bits 3..0 and zeros in bits 7..4, whatever the direction is. A write to address 2 changes no register.
- R8: A change on a pin input is first seen in the synchronized value after the second rising clock edge.
- R9: After reset the data and direction registers are 0, so with no peripheral enabled every output enable is 0. A read at address 1 returns the direction in bits 3..0 and 0 in bits 7..4.
- R10: The capture tap of a pin equals its synchronized pin value when its direction bit is 0, and is 0 when its direction bit is 1.
- R11: A read at address 3 returns 0, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address (0 data, 1 direction, 2 input, 3 reserved) |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ser_en_i | input | 4 | Per-pin serial function enable |
| ser_tx_i | input | 4 | Per-pin serial transmit select (0 = receive) |
| ser_out_i | input | 4 | Per-pin serial output value |
| tmr_en_i | input | 4 | Per-pin timer output-compare channel enable |
| tmr_out_i | input | 4 | Per-pin timer output value |
| pwm_en_i | input | 4 | Per-pin PWM channel enable |
| pwm_out_i | input | 4 | Per-pin PWM output value |
| pin_i | input | 4 | Pad input values |
| pin_o | output | 4 | Pad output values |
| pin_oe_o | output | 4 | Pad output enables |
| cap_o | output | 4 | Synchronized capture tap toward the timer |

## Verification
The arbitration is tried with every combination of:

- the serial enable and transmit select;
- the timer, PWM and serial output values and enables;
- the data bit and the direction bit.

Each pin receives a different rotation of the pattern, so a swapped priority level, a lost output enable or a crossed pin lane each shows up as a distinct miscompare. Read-path sweeps run all sixteen pin patterns against several direction patterns. These separate the direction-dependent data read from the direction-blind input read, and also check the capture gating. Single pin edges are sampled one and two edges later to pin down the synchronizer depth.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DIR  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_IN   = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_PWM  = 2'd1,
    OWN_TMR  = 2'd2,
    OWN_SER  = 2'd3
  } owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no reset: the synchronized pin state is unaffected by reset
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    stage_q[0] <= d_i;
    for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
  import gpio_mux_pkg::*;
(
  input  logic   ser_en_i,
  input  logic   ser_tx_i,
  input  logic   ser_out_i,
  input  logic   tmr_en_i,
  input  logic   tmr_out_i,
  input  logic   pwm_en_i,
  input  logic   pwm_out_i,
  input  logic   dir_i,
  input  logic   data_i,
  output owner_e owner_o,
  output logic   pin_o,
  output logic   oe_o
);
  always_comb begin
    if (ser_en_i)      owner_o = OWN_SER;
    else if (tmr_en_i) owner_o = OWN_TMR;
    else if (pwm_en_i) owner_o = OWN_PWM;
    else               owner_o = OWN_GPIO;
  end

  always_comb begin
    unique case (owner_o)
      OWN_SER: begin
        pin_o = ser_tx_i & ser_out_i;
        oe_o  = ser_tx_i;          // receive leaves the driver off
      end
      OWN_TMR: begin
        pin_o = tmr_out_i;
        oe_o  = 1'b1;
      end
      OWN_PWM: begin
        pin_o = pwm_out_i;
        oe_o  = 1'b1;
      end
      default: begin
        pin_o = data_i;
        oe_o  = dir_i;
      end
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_DW-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [REG_DW-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] dir_o
);
  localparam int unsigned PAD_W = REG_DW - NUM_PINS;

  logic [NUM_PINS-1:0] data_q, dir_q, data_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_DATA) data_q <= wdata_i[NUM_PINS-1:0];
      if (addr_i == ADDR_DIR)  dir_q  <= wdata_i[NUM_PINS-1:0];
    end
  end

  // register bit for outputs, pin for inputs
  assign data_rd = (data_q & dir_q) | (pin_sync_i & ~dir_q);

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = {{PAD_W{1'b0}}, data_rd};
      ADDR_DIR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      ADDR_IN:   rdata_o = {{PAD_W{1'b0}}, pin_sync_i};
      default:   rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] ser_en_i,
  input  logic [NUM_PINS-1:0] ser_tx_i,
  input  logic [NUM_PINS-1:0] ser_out_i,
  input  logic [NUM_PINS-1:0] tmr_en_i,
  input  logic [NUM_PINS-1:0] tmr_out_i,
  input  logic [NUM_PINS-1:0] pwm_en_i,
  input  logic [NUM_PINS-1:0] pwm_out_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] cap_o
);
  logic [NUM_PINS-1:0] pin_sync, data_q, dir_q;
  owner_e              owner [NUM_PINS];

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o),
    .data_o     (data_q),
    .dir_o      (dir_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_arb u_arb (
      .ser_en_i  (ser_en_i[i]),
      .ser_tx_i  (ser_tx_i[i]),
      .ser_out_i (ser_out_i[i]),
      .tmr_en_i  (tmr_en_i[i]),
      .tmr_out_i (tmr_out_i[i]),
      .pwm_en_i  (pwm_en_i[i]),
      .pwm_out_i (pwm_out_i[i]),
      .dir_i     (dir_q[i]),
      .data_i    (data_q[i]),
      .owner_o   (owner[i]),
      .pin_o     (pin_o[i]),
      .oe_o      (pin_oe_o[i])
    );
  end

  // capture sees the pin only while it is an input
  assign cap_o = pin_sync & ~dir_q;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int unsigned NUM_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          addr_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] ser_en_i,
  input logic [NUM_PINS-1:0] ser_tx_i,
  input logic [NUM_PINS-1:0] ser_out_i,
  input logic [NUM_PINS-1:0] tmr_en_i,
  input logic [NUM_PINS-1:0] tmr_out_i,
  input logic [NUM_PINS-1:0] pwm_en_i,
  input logic [NUM_PINS-1:0] pwm_out_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] cap_o,
  input logic [NUM_PINS-1:0] data_q,
  input logic [NUM_PINS-1:0] dir_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_ser_tx_owns_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_en_i[i] && ser_tx_i[i]) |-> (pin_oe_o[i] && pin_o[i] == ser_out_i[i]));
    assert_ser_rx_no_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_en_i[i] && !ser_tx_i[i]) |-> !pin_oe_o[i]);
    assert_tmr_owns_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_en_i[i] && tmr_en_i[i]) |-> (pin_oe_o[i] && pin_o[i] == tmr_out_i[i]));
    assert_pwm_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_en_i[i] && !tmr_en_i[i] && pwm_en_i[i]) |-> (pin_oe_o[i] && pin_o[i] == pwm_out_i[i]));
    assert_gpio_owns_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_en_i[i] && !tmr_en_i[i] && !pwm_en_i[i]) |->
        (pin_oe_o[i] == dir_q[i] && pin_o[i] == data_q[i]));
    assert_cap_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_q[i] |-> !cap_o[i]);
  end

  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> rdata_o[7:NUM_PINS] == '0);
  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> rdata_o == 8'h00);
  assert_reset_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (data_q == '0 && dir_q == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .ser_en_i  (ser_en_i),
  .ser_tx_i  (ser_tx_i),
  .ser_out_i (ser_out_i),
  .tmr_en_i  (tmr_en_i),
  .tmr_out_i (tmr_out_i),
  .pwm_en_i  (pwm_en_i),
  .pwm_out_i (pwm_out_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .cap_o     (cap_o),
  .data_q    (data_q),
  .dir_q     (dir_q)
);

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0, rdata;
  logic [N-1:0] ser_en = 0, ser_tx = 0, ser_out = 0, tmr_en = 0, tmr_out = 0;
  logic [N-1:0] pwm_en = 0, pwm_out = 0, pin_in = 0, pin_out, pin_oe, cap;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .ser_en_i(ser_en), .ser_tx_i(ser_tx), .ser_out_i(ser_out),
    .tmr_en_i(tmr_en), .tmr_out_i(tmr_out), .pwm_en_i(pwm_en), .pwm_out_i(pwm_out),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .cap_o(cap)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // wait for the synchronizer to settle after pin_in changes
  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R9 oe after reset", {4'h0, pin_oe}, 8'h00);
    bus_rd(2'd1, rd); chk("R9 dir after reset", rd, 8'h00);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, rd); chk("R9 dir readback", rd, 8'h0F);
    bus_rd(2'd0, rd); chk("R9 data after reset", rd, 8'h00);

    // exhaustive arbitration sweep, each pin a rotated pattern
    for (int v = 0; v < 512; v++) begin
      logic [N-1:0] dd, dr, eoe, eout;
      for (int k = 0; k < N; k++) begin
        int p = (v + k*73) % 512;
        ser_en[k] = p[0]; ser_tx[k] = p[1]; ser_out[k] = p[2];
        tmr_en[k] = p[3]; tmr_out[k] = p[4];
        pwm_en[k] = p[5]; pwm_out[k] = p[6];
        dd[k] = p[7]; dr[k] = p[8];
        if (p[0]) begin eoe[k] = p[1]; eout[k] = p[1] & p[2]; end
        else if (p[3]) begin eoe[k] = 1; eout[k] = p[4]; end
        else if (p[5]) begin eoe[k] = 1; eout[k] = p[6]; end
        else begin eoe[k] = p[8]; eout[k] = p[7]; end
      end
      bus_wr(2'd0, {4'hA, dd});
      bus_wr(2'd1, {4'h5, dr});
      #1;
      chk("R1 R2 R3 R4 R5 oe", {4'h0, pin_oe}, {4'h0, eoe});
      // serial receive pins leave pin_o unspecified
      chk("R1 R3 R4 R5 out", {4'h0, pin_out & eoe | (pin_out & ~ser_en)},
          {4'h0, eout & eoe | (eout & ~ser_en)});
    end
    ser_en = 0; tmr_en = 0; pwm_en = 0;

    // read path sweep: pins x direction
    for (int dv = 0; dv < 4; dv++) begin
      logic [3:0] dirv;
      dirv = (dv == 0) ? 4'h0 : (dv == 1) ? 4'hF : (dv == 2) ? 4'h5 : 4'hC;
      bus_wr(2'd0, 8'h96);
      bus_wr(2'd1, {4'h0, dirv});
      for (int pv = 0; pv < 16; pv++) begin
        @(negedge clk); pin_in = pv[3:0];
        settle();
        bus_rd(2'd0, rd); chk("R6 data read", rd, {4'h0, (4'h6 & dirv) | (pv[3:0] & ~dirv)});
        bus_rd(2'd2, rd); chk("R7 input read", rd, {4'h0, pv[3:0]});
        chk("R10 capture", {4'h0, cap}, {4'h0, pv[3:0] & ~dirv});
        bus_rd(2'd3, rd); chk("R11 reserved read", rd, 8'h00);
      end
    end

    // writes to input and reserved addresses change nothing
    bus_wr(2'd0, 8'h03); bus_wr(2'd1, 8'h05);
    bus_wr(2'd2, 8'hFF); bus_wr(2'd3, 8'hFF);
    bus_rd(2'd1, rd); chk("R7 R11 dir unchanged", rd, 8'h05);
    bus_wr(2'd1, 8'h0F);
    bus_rd(2'd0, rd); chk("R7 R11 data unchanged", rd, 8'h03);
    bus_rd(2'd2, rd); chk("R7 input after write", rd, {4'h0, pin_in});

    // synchronizer depth
    bus_wr(2'd1, 8'h00);
    @(negedge clk); pin_in = 4'h0; settle();
    @(negedge clk); pin_in = 4'hB;
    @(negedge clk); addr = 2'd2; #1 chk("R8 after one edge", rdata, 8'h00);
    @(negedge clk); #1 chk("R8 after two edges", rdata, 8'h0B);
    chk("R8 capture two edges", {4'h0, cap}, 8'h0B);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    done = 1;
    $finish;
  end
endmodule